// File: doc/BRIEF.md
# Dual-Panel LCD Frame Address Generator

This block produces the memory fetch addresses that an LCD controller uses to pull frame buffer data. It holds two address channels. Channel A feeds the upper half of a split display, or the whole display when only one panel is attached. Channel B feeds the lower half and is only active when split-panel mode is selected. Each channel has a software-written base pointer, a frame length and a read-only current pointer. The current pointer walks through the buffer one 16-byte burst per granted fetch. When the next burst would reach the end of the frame, the pointer returns to the base.

A small run controller has three states. ST_OFF is the state while the display is disabled. ST_START lasts one cycle after enable is seen. On the OFF-to-START transition both current pointers load from their bases. ST_RUN issues fetches. Its transitions are: OFF to START when enable is 1, START to RUN when enable stays 1, START to OFF when enable drops, and RUN to OFF when enable drops. An update flag is set at each end-of-frame reload. The flag tells software that a new base may be written, and it can raise an interrupt. Base writes made while the display runs and the flag is clear are discarded.

Software first writes control with enable 0 and split mode set. It then writes base A, base B and both lengths, and finally sets enable. Channel A's length includes any palette area at the head of its buffer. Channel B's buffer holds pixels only.

Top module: `lcd_dual_dma_addr`

## Requirements
- R1: After reset, fetch_req and irq are 0, and every register reads as zero. The register offsets are: 0 control (bit0 enable, bit1 split mode, bit2 interrupt enable), 1 base A, 2 base B, 3 current A, 4 current B, 5 length A, 6 length B, 7 status (bit0 update flag).
- R2: Bits 3:0 of any base or length write are stored as zero.
- R3: Writing enable from 0 to 1 loads both current pointers from their bases. fetch_req rises two clock edges after the edge that stored enable.
- R4: Each granted fetch advances the serving channel's current pointer by 16. fetch_chan is 0 for channel A and 1 for channel B.
- R5: On a grant where current+16 equals the frame end, the current pointer reloads from the base register and the update flag sets. The frame end is the base plus the length, captured at the last load.
- R6: A base write is accepted while enable is 0 or while the update flag is 1. Otherwise it is ignored.
- R7: Writes to the current-pointer offsets have no effect.
- R8: With split mode 0 every fetch is on channel A. Channel B requests only when split mode is 1.
- R9: When both channels request, grants alternate between them. Channel A is served first after every enable.
- R10: fetch_req is 0 from the edge that clears enable. The controller then returns to ST_OFF.
- R11: Writing 1 to status bit0 clears the flag. irq is high exactly when the flag and interrupt enable are both 1.
- R12: fetch_addr always has bits 3:0 equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data at reg_addr (combinational) |
| fetch_req | output | 1 | A fetch address is offered |
| fetch_chan | output | 1 | Channel of the offered address |
| fetch_addr | output | 32 | Byte address of the burst |
| fetch_gnt | input | 1 | Memory side accepts the offered fetch |
| irq | output | 1 | Update-flag interrupt request |

## Verification
On every cycle, the assertions check that requests only occur while the display is enabled, that addresses stay 16-byte aligned, and that channel B requests only in split mode. They also check that grants alternate when both channels compete, that the flag rises only after a grant, and that a current pointer changes only on a load or on its own grant. The bench scenarios show the actual address sequences and the wrap points. They also show that base writes are refused and then accepted around the flag, that the first grant after enable goes to channel A, and that writes to the current registers are ignored.

// File: rtl/lcd_dma_pkg.sv
package lcd_dma_pkg;
    typedef enum logic [1:0] {ST_OFF, ST_START, ST_RUN} run_state_e;

    localparam logic [2:0] OFS_CTRL   = 3'd0;
    localparam logic [2:0] OFS_BASE_A = 3'd1;
    localparam logic [2:0] OFS_BASE_B = 3'd2;
    localparam logic [2:0] OFS_CUR_A  = 3'd3;
    localparam logic [2:0] OFS_CUR_B  = 3'd4;
    localparam logic [2:0] OFS_LEN_A  = 3'd5;
    localparam logic [2:0] OFS_LEN_B  = 3'd6;
    localparam logic [2:0] OFS_STAT   = 3'd7;
endpackage

// File: rtl/lcd_dma_regs.sv
module lcd_dma_regs
    import lcd_dma_pkg::*;
#(
    parameter int AW       = 32,
    parameter int QW_SHIFT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          addr,
    input  logic [AW-1:0]       wr_data,
    output logic [AW-1:0]       rd_data,
    input  logic [1:0][AW-1:0]  cur,
    input  logic                reload_evt,
    output logic                en,
    output logic                dual,
    output logic                irq_en,
    output logic [1:0][AW-1:0]  base,
    output logic [1:0][AW-1:0]  len,
    output logic                flag
);
    logic [AW-1:0] align_mask;
    logic          base_ok;

    assign align_mask = {AW{1'b1}} << QW_SHIFT;
    assign base_ok    = !en || flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en     <= 1'b0;
            dual   <= 1'b0;
            irq_en <= 1'b0;
        end else if (wr_en && addr == OFS_CTRL) begin
            en     <= wr_data[0];
            dual   <= wr_data[1];
            irq_en <= wr_data[2];
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_ch_regs
        localparam logic [2:0] BASE_OFS = OFS_BASE_A + 3'(i);
        localparam logic [2:0] LEN_OFS  = OFS_LEN_A + 3'(i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base[i] <= '0;
                len[i]  <= '0;
            end else if (wr_en) begin
                if (addr == BASE_OFS && base_ok) base[i] <= wr_data & align_mask;
                if (addr == LEN_OFS)             len[i]  <= wr_data & align_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                          flag <= 1'b0;
        else if (reload_evt)                                 flag <= 1'b1;
        else if (wr_en && addr == OFS_STAT && wr_data[0])    flag <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            OFS_CTRL:   rd_data = AW'({irq_en, dual, en});
            OFS_BASE_A: rd_data = base[0];
            OFS_BASE_B: rd_data = base[1];
            OFS_CUR_A:  rd_data = cur[0];
            OFS_CUR_B:  rd_data = cur[1];
            OFS_LEN_A:  rd_data = len[0];
            OFS_LEN_B:  rd_data = len[1];
            OFS_STAT:   rd_data = AW'(flag);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/lcd_dma_chan.sv
module lcd_dma_chan #(
    parameter int AW   = 32,
    parameter int STEP = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] cur,
    output logic          wrap
);
    logic [AW-1:0] end_q;
    logic [AW-1:0] nxt;

    assign nxt  = cur + AW'(STEP);
    assign wrap = adv && (nxt == end_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= '0;
            end_q <= '0;
        end else if (load || wrap) begin
            cur   <= base;
            end_q <= base + len;
        end else if (adv) begin
            cur   <= nxt;
        end
    end
endmodule

// File: rtl/lcd_dma_arb.sv
module lcd_dma_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] req,
    input  logic       gnt_in,
    output logic       pick,
    output logic [1:0] adv
);
    logic last_q;

    always_comb begin
        if (req == 2'b11) pick = ~last_q;
        else              pick = req[1];
        adv = '0;
        if (gnt_in && |req) adv[pick] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              last_q <= 1'b1;
        else if (restart)        last_q <= 1'b1;
        else if (gnt_in && |req) last_q <= pick;
    end
endmodule

// File: rtl/lcd_dual_dma_addr.sv
module lcd_dual_dma_addr
    import lcd_dma_pkg::*;
#(
    parameter int AW       = 32,
    parameter int QW_SHIFT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          fetch_req,
    output logic          fetch_chan,
    output logic [AW-1:0] fetch_addr,
    input  logic          fetch_gnt,
    output logic          irq
);
    localparam int STEP = 1 << QW_SHIFT;

    run_state_e         state_q, state_d;
    logic               en, dual, irq_en, flag;
    logic [1:0][AW-1:0] base_w, len_w, cur_w;
    logic [1:0]         wrap_w, adv_w, req_w;
    logic               load, pick;

    lcd_dma_regs #(.AW(AW), .QW_SHIFT(QW_SHIFT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wr_data(reg_wdata), .rd_data(reg_rdata), .cur(cur_w),
        .reload_evt(|wrap_w), .en(en), .dual(dual), .irq_en(irq_en),
        .base(base_w), .len(len_w), .flag(flag)
    );

    for (genvar i = 0; i < 2; i++) begin : g_chan
        lcd_dma_chan #(.AW(AW), .STEP(STEP)) u_chan (
            .clk(clk), .rst_n(rst_n), .load(load), .adv(adv_w[i]),
            .base(base_w[i]), .len(len_w[i]), .cur(cur_w[i]), .wrap(wrap_w[i])
        );
    end

    lcd_dma_arb u_arb (
        .clk(clk), .rst_n(rst_n), .restart(load), .req(req_w),
        .gnt_in(fetch_gnt), .pick(pick), .adv(adv_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en)  state_d = ST_START;
            ST_START: state_d = en ? ST_RUN : ST_OFF;
            ST_RUN:   if (!en) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    always_comb begin
        load  = (state_q == ST_OFF) && en;
        req_w = (state_q == ST_RUN && en) ? {dual, 1'b1} : 2'b00;
    end

    assign fetch_req  = |req_w;
    assign fetch_chan = pick;
    assign fetch_addr = cur_w[pick];
    assign irq        = flag && irq_en;
endmodule

// File: rtl/lcd_dma_checker.sv
module lcd_dma_checker #(
    parameter int AW       = 32,
    parameter int QW_SHIFT = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_req,
    input logic          fetch_gnt,
    input logic          fetch_chan,
    input logic [AW-1:0] fetch_addr,
    input logic          en,
    input logic          dual,
    input logic          flag,
    input logic [1:0]    req,
    input logic          load,
    input logic [AW-1:0] cur_a,
    input logic [AW-1:0] cur_b
);
    logic [AW-1:0] low_mask;
    assign low_mask = ~({AW{1'b1}} << QW_SHIFT);

    assert_req_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> en);

    assert_addr_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> ((fetch_addr & low_mask) == '0));

    assert_lower_split_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_chan) |-> dual);

    assert_alternate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((req == 2'b11) && $past(req == 2'b11 && fetch_gnt)) |-> (fetch_chan != $past(fetch_chan)));

    assert_flag_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(fetch_req && fetch_gnt));

    assert_cur_a_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_a) |-> $past(load || (fetch_req && fetch_gnt && !fetch_chan)));

    assert_cur_b_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_b) |-> $past(load || (fetch_req && fetch_gnt && fetch_chan)));
endmodule

bind lcd_dual_dma_addr lcd_dma_checker #(.AW(AW), .QW_SHIFT(QW_SHIFT)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_gnt(fetch_gnt),
    .fetch_chan(fetch_chan), .fetch_addr(fetch_addr), .en(en), .dual(dual),
    .flag(flag), .req(req_w), .load(load), .cur_a(cur_w[0]), .cur_b(cur_w[1])
);

// File: tb/lcd_dual_dma_addr_bench.sv
`timescale 1ns/1ps
module lcd_dual_dma_addr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_req, fetch_chan, fetch_gnt = 1'b0, irq;
    logic [31:0] fetch_addr;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lcd_dual_dma_addr u_lcd_dual_dma_addr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
        .fetch_chan(fetch_chan), .fetch_addr(fetch_addr), .fetch_gnt(fetch_gnt),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic grant(input string tag, input logic ch, input logic [31:0] addr);
        check({tag, " req"}, 32'(fetch_req), 32'd1);
        check({tag, " chan"}, 32'(fetch_chan), 32'(ch));
        check({tag, " addr"}, fetch_addr, addr);
        fetch_gnt = 1'b1;
        @(negedge clk);
        fetch_gnt = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 fetch_req", 32'(fetch_req), 0);
        check("R1 irq", 32'(irq), 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reg", v, 0);
        end
    endtask

    task automatic t_single();
        logic [31:0] v;
        wr(3'd0, 32'h4);
        wr(3'd1, 32'h1005);
        rd(3'd1, v); check("R2 base low bits", v, 32'h1000);
        wr(3'd5, 32'h4A);
        rd(3'd5, v); check("R2 len low bits", v, 32'h40);
        wr(3'd0, 32'h5);
        check("R3 no req in START path", 32'(fetch_req), 0);
        @(negedge clk); @(negedge clk);
        check("R3 req after enable", 32'(fetch_req), 1);
        rd(3'd3, v); check("R3 cur A loaded", v, 32'h1000);
        wr(3'd1, 32'h3000);
        rd(3'd1, v); check("R6 base write refused", v, 32'h1000);
        wr(3'd3, 32'hFFF0);
        rd(3'd3, v); check("R7 cur A unchanged", v, 32'h1000);
        check("R7 addr unchanged", fetch_addr, 32'h1000);
        grant("R4 g0", 0, 32'h1000);
        grant("R4 g1", 0, 32'h1010);
        grant("R8 g2", 0, 32'h1020);
        check("R5 flag clear before end", 32'(irq), 0);
        grant("R8 g3", 0, 32'h1030);
        rd(3'd7, v); check("R5 flag set", v, 1);
        check("R11 irq", 32'(irq), 1);
        rd(3'd3, v); check("R5 cur A reload", v, 32'h1000);
    endtask

    task automatic t_base_update();
        logic [31:0] v;
        wr(3'd1, 32'h3000);
        rd(3'd1, v); check("R6 base write accepted", v, 32'h3000);
        wr(3'd7, 32'h1);
        rd(3'd7, v); check("R11 flag cleared", v, 0);
        check("R11 irq low", 32'(irq), 0);
        grant("R5 old frame 0", 0, 32'h1000);
        grant("R5 old frame 1", 0, 32'h1010);
        grant("R5 old frame 2", 0, 32'h1020);
        grant("R5 old frame 3", 0, 32'h1030);
        check("R5 new base used", fetch_addr, 32'h3000);
        wr(3'd0, 32'h1);
        check("R11 irq masked", 32'(irq), 0);
        rd(3'd7, v); check("R11 flag held", v, 1);
    endtask

    task automatic t_disable();
        wr(3'd0, 32'h0);
        check("R10 req drops", 32'(fetch_req), 0);
        @(negedge clk); @(negedge clk);
        check("R10 stays off", 32'(fetch_req), 0);
    endtask

    task automatic t_dual();
        logic [31:0] v;
        wr(3'd7, 32'h1);
        wr(3'd0, 32'h2);
        wr(3'd1, 32'h2000);
        wr(3'd2, 32'h8000);
        wr(3'd5, 32'h20);
        wr(3'd6, 32'h30);
        wr(3'd0, 32'h3);
        @(negedge clk); @(negedge clk);
        rd(3'd4, v); check("R3 cur B loaded", v, 32'h8000);
        grant("R9 first A", 0, 32'h2000);
        grant("R9 d1", 1, 32'h8000);
        grant("R9 d2", 0, 32'h2010);
        grant("R9 d3", 1, 32'h8010);
        grant("R5 A wrapped", 0, 32'h2000);
        grant("R9 d5", 1, 32'h8020);
        grant("R9 d6", 0, 32'h2010);
        grant("R5 B wrapped", 1, 32'h8000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_base_update();
        t_disable();
        t_dual();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule